// File: doc/BRIEF.md
# Interrupt Event Routing Sequencer

This block takes a source interrupt number and works out what happens to it. It fetches the routing entry for that source. From the entry it reaches an event descriptor, and it may append the event data to an in-memory event queue. It then applies the descriptor's coalescing state and finds the target processor record. Finally it asks a presenter to deliver the event. If the presenter reports that no matching processor is dispatched, the sequencer can record the event's priority in the processor's pending byte.

A descriptor can also forward the event to a second descriptor as an escalation. The sequencer then re-enters the descriptor stage with a new block, index and data. A depth counter caps how many escalations one trigger may chain.

Every table access, read or write, goes through a single request/acknowledge port. The presenter is a single request/acknowledge handshake that returns a found flag. One trigger is handled at a time. Each trigger ends with a one-cycle `done` pulse that carries an outcome code: 1 delivered, 2 ended quietly, 3 aborted, 4 escalation limit reached.

Top module: `evr_engine`

## Requirements
- R1: A trigger is taken only while `trig_ready` is high, and `trig_ready` drops in the next cycle. The upper BLK_W bits of `trig_src` select the block and the lower IDX_W bits select the index of the routing entry, which is read with select 0. A routing entry with bit 63 clear or `tbl_ok` low ends the trigger with code 3.
- R2: A routing entry with bit 62 set (masked) ends the trigger with code 2. A routing entry carries the descriptor block in bits 55:48, the descriptor index in bits 47:32 and the event data in bits 30:0.
- R3: Descriptor word 0 is read with select 1. If its bit 63 (valid) is clear or `tbl_ok` is low, the trigger ends with code 3. The descriptor's flag bits are: 62 enqueue, 61 always-notify, 60 backlog, 59 escalate, 58 unconditional escalation, 57 silent, 56 format.
- R4: With enqueue set, the sequencer writes {generation, data} with select 4. The write goes to the descriptor block, at the queue index in bits 46:32. It then advances the index modulo 2^(bits 51:48), toggles the generation (bit 47) when the index wraps to 0, and writes descriptor word 0 back.
- R5: With silent set, the notification stage is skipped: no processor lookup and no presenter request happen, and the sequencer goes straight to the escalation stage.
- R6: With format 0, a priority (bits 31:24) of 0xFF ends the trigger with code 2. With format 1 the value 0xFF does not mask.
- R7: With always-notify clear, the notify state pair (bits 55:54, P high) is updated by a trigger. 00 becomes 10 and processing continues. 10 and 11 become 11, and 01 stays 01; in these cases the trigger ends with code 2. A changed pair is written back.
- R8: The processor record is read with select 3, at the block in bits 23:16 and the index in bits 15:0. If the record is invalid (bit 63 clear) or missing, the trigger ends with code 3. A found response from the presenter ends the trigger with code 1. A miss with neither backlog nor escalation set ends it with code 2.
- R9: On a presenter miss with backlog set and format 0, bit (7 - priority) is ORed into the record's pending byte (bits 7:0) and the record is written back. Backlog together with format 1 ends the trigger with code 3.
- R10: With escalate set, the escalation pair (bits 53:52) is updated by the same trigger rule unless unconditional escalation is set. On continue, descriptor word 1 (select 2, laid out like a routing entry) supplies the next block, index and data, and the descriptor stage restarts.
- R11: A trigger that would chain more than MAX_ESC escalations ends with code 4.
- R12: After reset, `trig_ready` is high and `done`, `tbl_req` and `pres_req` are low. `done` lasts exactly one cycle, after which `trig_ready` is high again. Requests hold their select and address until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Source trigger strobe |
| trig_src | input | BLK_W+IDX_W | Source number (block, index) |
| trig_ready | output | 1 | Sequencer idle, trigger accepted |
| tbl_req | output | 1 | Table access request |
| tbl_we | output | 1 | Access is a write |
| tbl_sel | output | 3 | Table select (0 routing, 1 descriptor word 0, 2 descriptor word 1, 3 processor, 4 queue) |
| tbl_blk | output | 8 | Table block |
| tbl_idx | output | 16 | Table index |
| tbl_wdata | output | 64 | Write data |
| tbl_ack | input | 1 | Access completed |
| tbl_ok | input | 1 | Entry exists |
| tbl_rdata | input | 64 | Read data |
| pres_req | output | 1 | Delivery request to presenter |
| pres_blk | output | 8 | Target processor block |
| pres_idx | output | 16 | Target processor index |
| pres_prio | output | 8 | Event priority |
| pres_fmt | output | 1 | Descriptor format bit |
| pres_ack | input | 1 | Presenter response valid |
| pres_found | input | 1 | A dispatched processor took the event |
| done | output | 1 | One-cycle end-of-trigger pulse |
| done_code | output | 3 | Outcome code |

## Verification
The assertions assume that the environment answers each table request and each presenter request eventually. They also assume that `tbl_ok`, `tbl_rdata` and `pres_found` are valid in the acknowledge cycle. The bench's table model acknowledges in the same cycle as the request and returns data from its own arrays, so every handshake completes. The bench raises `trig_valid` only while `trig_ready` is high. It rewrites the tables only between triggers, so no table contents change while a walk is in progress.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int WORD_W = 64;
  localparam int TBLK_W = 8;
  localparam int TIDX_W = 16;
  localparam int DATA_W = 31;
  localparam int QIDX_W = 15;
  localparam int QSZ_W  = 4;

  // routing entry / escalation word layout
  localparam int RT_V      = 63;
  localparam int RT_M      = 62;
  localparam int RT_BLK_LO = 48;
  localparam int RT_IDX_LO = 32;

  // descriptor word 0 layout
  localparam int D_V     = 63;
  localparam int D_ENQ   = 62;
  localparam int D_ANOT  = 61;
  localparam int D_BLOG  = 60;
  localparam int D_ESC   = 59;
  localparam int D_UESC  = 58;
  localparam int D_SIL   = 57;
  localparam int D_FMT   = 56;
  localparam int D_NPQ   = 54;
  localparam int D_EPQ   = 52;
  localparam int D_QSZ   = 48;
  localparam int D_GEN   = 47;
  localparam int D_QIDX  = 32;
  localparam int D_PRIO  = 24;
  localparam int D_PBLK  = 16;
  localparam int PR_V    = 63;

  typedef enum logic [2:0] {
    SEL_RT = 3'd0, SEL_D0 = 3'd1, SEL_D1 = 3'd2, SEL_PR = 3'd3, SEL_Q = 3'd4
  } tsel_e;

  typedef enum logic [2:0] {
    RES_NONE = 3'd0, RES_DELIV = 3'd1, RES_QUIET = 3'd2,
    RES_ABORT = 3'd3, RES_LIMIT = 3'd4
  } res_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RT, S_DSC, S_QWR, S_DWB, S_NOTE, S_PROC,
    S_PRES, S_BLOG, S_ESC, S_ESCR, S_FIN
  } st_e;
endpackage

// File: rtl/evr_pq_trigger.sv
module evr_pq_trigger (
  input  logic [1:0] pq_cur,
  output logic [1:0] pq_nxt,
  output logic       fire
);
  always_comb begin
    fire   = 1'b0;
    pq_nxt = pq_cur;
    unique case (pq_cur)
      2'b00: begin pq_nxt = 2'b10; fire = 1'b1; end
      2'b10, 2'b11: pq_nxt = 2'b11;
      default: pq_nxt = pq_cur;
    endcase
  end

  // R7
  always_comb begin
    pq_nxt_nonreset_chk: assert (pq_nxt != 2'b00);
  end
endmodule

// File: rtl/evr_queue_advance.sv
module evr_queue_advance #(
  parameter int QIDX_W = 15,
  parameter int QSZ_W  = 4
) (
  input  logic [QIDX_W-1:0] idx_cur,
  input  logic              gen_cur,
  input  logic [QSZ_W-1:0]  qsz,
  output logic [QIDX_W-1:0] idx_nxt,
  output logic              gen_nxt
);
  logic [QIDX_W:0] span;
  logic [QIDX_W:0] bumped;

  always_comb begin
    span    = (QIDX_W+1)'(1) << qsz;
    bumped  = ({1'b0, idx_cur} + (QIDX_W+1)'(1)) & (span - (QIDX_W+1)'(1));
    idx_nxt = bumped[QIDX_W-1:0];
    gen_nxt = gen_cur ^ (bumped == '0);
  end

  // R4
  always_comb begin
    if (gen_nxt != gen_cur) wrap_at_zero_chk: assert (idx_nxt == '0);
  end
endmodule

// File: rtl/evr_prio_bit.sv
module evr_prio_bit (
  input  logic [7:0] prio,
  output logic [7:0] pmask
);
  always_comb begin
    pmask = (prio < 8'd8) ? (8'h80 >> prio[2:0]) : 8'h00;
  end

  // R9
  always_comb begin
    prio_onehot_chk: assert ($onehot0(pmask));
  end
endmodule

// File: rtl/evr_engine.sv
module evr_engine
  import evr_pkg::*;
#(
  parameter int BLK_W   = 4,
  parameter int IDX_W   = 6,
  parameter int MAX_ESC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig_valid,
  input  logic [BLK_W+IDX_W-1:0] trig_src,
  output logic                   trig_ready,
  output logic                   tbl_req,
  output logic                   tbl_we,
  output logic [2:0]             tbl_sel,
  output logic [7:0]             tbl_blk,
  output logic [15:0]            tbl_idx,
  output logic [63:0]            tbl_wdata,
  input  logic                   tbl_ack,
  input  logic                   tbl_ok,
  input  logic [63:0]            tbl_rdata,
  output logic                   pres_req,
  output logic [7:0]             pres_blk,
  output logic [15:0]            pres_idx,
  output logic [7:0]             pres_prio,
  output logic                   pres_fmt,
  input  logic                   pres_ack,
  input  logic                   pres_found,
  output logic                   done,
  output logic [2:0]             done_code
);
  localparam int SRC_W   = BLK_W + IDX_W;
  localparam int DEPTH_W = $clog2(MAX_ESC + 1);

  logic [1:0] rs_q;
  logic       arst_n;

  st_e                 state_q, state_d, ret_q, ret_d;
  res_e                res_q, res_d;
  logic [SRC_W-1:0]    src_q, src_d;
  logic [TBLK_W-1:0]   cur_blk_q, cur_blk_d;
  logic [TIDX_W-1:0]   cur_idx_q, cur_idx_d;
  logic [DATA_W-1:0]   data_q, data_d;
  logic [WORD_W-1:0]   dsc_q, dsc_d, proc_q, proc_d;
  logic [DEPTH_W-1:0]  depth_q, depth_d;

  logic [1:0]        pq_in, pq_out;
  logic              pq_fire;
  logic [QIDX_W-1:0] qidx_nxt;
  logic              gen_nxt;
  logic [7:0]        pmask;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  assign pq_in = (state_q == S_ESC) ? dsc_q[D_EPQ+:2] : dsc_q[D_NPQ+:2];

  evr_pq_trigger u_pq (.pq_cur(pq_in), .pq_nxt(pq_out), .fire(pq_fire));

  evr_queue_advance #(.QIDX_W(QIDX_W), .QSZ_W(QSZ_W)) u_qadv (
    .idx_cur(dsc_q[D_QIDX+:QIDX_W]), .gen_cur(dsc_q[D_GEN]),
    .qsz(dsc_q[D_QSZ+:QSZ_W]), .idx_nxt(qidx_nxt), .gen_nxt(gen_nxt));

  evr_prio_bit u_pbit (.prio(dsc_q[D_PRIO+:8]), .pmask(pmask));

  // next-state process
  always_comb begin
    state_d = state_q; ret_d = ret_q; res_d = res_q; src_d = src_q;
    cur_blk_d = cur_blk_q; cur_idx_d = cur_idx_q; data_d = data_q;
    dsc_d = dsc_q; proc_d = proc_q; depth_d = depth_q;
    unique case (state_q)
      S_IDLE: if (trig_valid) begin
        src_d = trig_src; depth_d = '0; state_d = S_RT;
      end
      S_RT: if (tbl_ack) begin
        if (!tbl_ok || !tbl_rdata[RT_V]) begin res_d = RES_ABORT; state_d = S_FIN; end
        else if (tbl_rdata[RT_M])        begin res_d = RES_QUIET; state_d = S_FIN; end
        else begin
          cur_blk_d = tbl_rdata[RT_BLK_LO+:TBLK_W];
          cur_idx_d = tbl_rdata[RT_IDX_LO+:TIDX_W];
          data_d    = tbl_rdata[DATA_W-1:0];
          state_d   = S_DSC;
        end
      end
      S_DSC: if (tbl_ack) begin
        dsc_d = tbl_rdata;
        if (!tbl_ok || !tbl_rdata[D_V]) begin res_d = RES_ABORT; state_d = S_FIN; end
        else state_d = tbl_rdata[D_ENQ] ? S_QWR : S_NOTE;
      end
      S_QWR: if (tbl_ack) begin
        dsc_d[D_QIDX+:QIDX_W] = qidx_nxt;
        dsc_d[D_GEN]          = gen_nxt;
        ret_d   = S_NOTE;
        state_d = S_DWB;
      end
      S_DWB: if (tbl_ack) state_d = ret_q;
      S_NOTE: begin
        if (dsc_q[D_SIL]) state_d = S_ESC;
        else if (!dsc_q[D_FMT] && dsc_q[D_PRIO+:8] == 8'hFF) begin
          res_d = RES_QUIET; state_d = S_FIN;
        end else if (dsc_q[D_ANOT]) state_d = S_PROC;
        else begin
          dsc_d[D_NPQ+:2] = pq_out;
          res_d = RES_QUIET;
          ret_d = pq_fire ? S_PROC : S_FIN;
          state_d = (pq_out != pq_in) ? S_DWB : S_FIN;
        end
      end
      S_PROC: if (tbl_ack) begin
        proc_d = tbl_rdata;
        if (!tbl_ok || !tbl_rdata[PR_V]) begin res_d = RES_ABORT; state_d = S_FIN; end
        else state_d = S_PRES;
      end
      S_PRES: if (pres_ack) begin
        if (pres_found) begin res_d = RES_DELIV; state_d = S_FIN; end
        else if (dsc_q[D_BLOG]) begin
          if (dsc_q[D_FMT]) begin res_d = RES_ABORT; state_d = S_FIN; end
          else state_d = S_BLOG;
        end else state_d = S_ESC;
      end
      S_BLOG: if (tbl_ack) state_d = S_ESC;
      S_ESC: begin
        if (!dsc_q[D_ESC]) begin res_d = RES_QUIET; state_d = S_FIN; end
        else if (dsc_q[D_UESC]) state_d = S_ESCR;
        else begin
          dsc_d[D_EPQ+:2] = pq_out;
          res_d = RES_QUIET;
          ret_d = pq_fire ? S_ESCR : S_FIN;
          state_d = (pq_out != pq_in) ? S_DWB : S_FIN;
        end
      end
      S_ESCR: if (tbl_ack) begin
        if (!tbl_ok) begin res_d = RES_ABORT; state_d = S_FIN; end
        else if (depth_q == DEPTH_W'(MAX_ESC)) begin res_d = RES_LIMIT; state_d = S_FIN; end
        else begin
          depth_d   = depth_q + DEPTH_W'(1);
          cur_blk_d = tbl_rdata[RT_BLK_LO+:TBLK_W];
          cur_idx_d = tbl_rdata[RT_IDX_LO+:TIDX_W];
          data_d    = tbl_rdata[DATA_W-1:0];
          state_d   = S_DSC;
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= S_IDLE; ret_q <= S_IDLE; res_q <= RES_NONE; src_q <= '0;
      cur_blk_q <= '0; cur_idx_q <= '0; data_q <= '0;
      dsc_q <= '0; proc_q <= '0; depth_q <= '0;
    end else begin
      state_q <= state_d; ret_q <= ret_d; res_q <= res_d; src_q <= src_d;
      cur_blk_q <= cur_blk_d; cur_idx_q <= cur_idx_d; data_q <= data_d;
      dsc_q <= dsc_d; proc_q <= proc_d; depth_q <= depth_d;
    end
  end

  // port drive
  always_comb begin
    tbl_req = 1'b1; tbl_we = 1'b0; tbl_sel = SEL_D0;
    tbl_blk = cur_blk_q; tbl_idx = cur_idx_q; tbl_wdata = dsc_q;
    unique case (state_q)
      S_RT: begin
        tbl_sel = SEL_RT;
        tbl_blk = TBLK_W'(src_q[SRC_W-1:IDX_W]);
        tbl_idx = TIDX_W'(src_q[IDX_W-1:0]);
      end
      S_DSC: tbl_sel = SEL_D0;
      S_QWR: begin
        tbl_we = 1'b1; tbl_sel = SEL_Q;
        tbl_idx = TIDX_W'(dsc_q[D_QIDX+:QIDX_W]);
        tbl_wdata = {32'd0, dsc_q[D_GEN], data_q};
      end
      S_DWB: tbl_we = 1'b1;
      S_PROC: begin
        tbl_sel = SEL_PR; tbl_blk = dsc_q[D_PBLK+:8]; tbl_idx = dsc_q[15:0];
      end
      S_BLOG: begin
        tbl_we = 1'b1; tbl_sel = SEL_PR;
        tbl_blk = dsc_q[D_PBLK+:8]; tbl_idx = dsc_q[15:0];
        tbl_wdata = {proc_q[63:8], proc_q[7:0] | pmask};
      end
      S_ESCR: tbl_sel = SEL_D1;
      default: tbl_req = 1'b0;
    endcase
  end

  assign pres_req   = (state_q == S_PRES);
  assign pres_blk   = dsc_q[D_PBLK+:8];
  assign pres_idx   = dsc_q[15:0];
  assign pres_prio  = dsc_q[D_PRIO+:8];
  assign pres_fmt   = dsc_q[D_FMT];
  assign trig_ready = (state_q == S_IDLE);
  assign done       = (state_q == S_FIN);
  assign done_code  = res_q;

  // R12
  tbl_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    tbl_req && !tbl_ack |=> tbl_req && $stable(tbl_sel) && $stable(tbl_blk) && $stable(tbl_idx));
  // R8
  pres_hold_chk: assert property (@(posedge clk) disable iff (!arst_n)
    pres_req && !pres_ack |=> pres_req);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
    done |=> trig_ready && !done);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!arst_n)
    trig_valid && trig_ready |=> !trig_ready);
  // R11
  depth_bound_chk: assert property (@(posedge clk) disable iff (!arst_n)
    depth_q <= DEPTH_W'(MAX_ESC));
  // R4
  dsc_wb_valid_chk: assert property (@(posedge clk) disable iff (!arst_n)
    tbl_req && tbl_we && tbl_sel == SEL_D0 |-> tbl_wdata[D_V]);
  // R12
  done_code_chk: assert property (@(posedge clk) disable iff (!arst_n)
    done |-> done_code != RES_NONE);
endmodule

// File: tb/evr_engine_test.sv
module evr_engine_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, trig_valid, trig_ready;
  logic [9:0]  trig_src;
  logic        tbl_req, tbl_we, tbl_ack, tbl_ok;
  logic [2:0]  tbl_sel;
  logic [7:0]  tbl_blk;
  logic [15:0] tbl_idx;
  logic [63:0] tbl_wdata, tbl_rdata;
  logic        pres_req, pres_fmt, pres_ack, pres_found, done;
  logic [7:0]  pres_blk, pres_prio;
  logic [15:0] pres_idx;
  logic [2:0]  done_code;

  evr_engine uut (.*);

  localparam logic [7:0] F_V = 8'h80, F_ENQ = 8'h40, F_ANOT = 8'h20, F_BLOG = 8'h10,
                         F_ESC = 8'h08, F_UESC = 8'h04, F_SIL = 8'h02, F_FMT = 8'h01;

  function automatic logic [63:0] mk_rt(input logic v, input logic m, input logic [7:0] b,
                                        input logic [15:0] i, input logic [30:0] d);
    return {v, m, 6'd0, b, i, 1'b0, d};
  endfunction
  function automatic logic [63:0] mk_d0(input logic [7:0] fl, input logic [1:0] npq,
      input logic [1:0] epq, input logic [3:0] qsz, input logic gen,
      input logic [14:0] qidx, input logic [7:0] prio);
    return {fl, npq, epq, qsz, gen, qidx, prio, 8'd1, 16'd7};
  endfunction
  function automatic logic [63:0] mk_pr(input logic v, input logic [7:0] pend);
    return {v, 55'd0, pend};
  endfunction
  function automatic logic [5:0] key(input logic [7:0] b, input logic [15:0] i);
    return {b[1:0], i[3:0]};
  endfunction

  localparam logic [63:0] RT0  = mk_rt(1'b1, 1'b0, 8'd2, 16'd3, 31'h55);
  localparam logic [63:0] ESCB = mk_rt(1'b1, 1'b0, 8'd2, 16'd9, 31'h1234);
  localparam logic [63:0] PRK  = mk_pr(1'b1, 8'h00);

  typedef struct packed {
    logic [63:0] rt, da, dae, db, pr;
    logic        fnd;
    logic [2:0]  exp;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{RT0, mk_d0(F_V|F_ANOT,0,0,0,0,0,8'd4), 64'd0, 64'd0, PRK, 1'b1, 3'd1, 8'd8},   // R8 delivered
    '{mk_rt(1,1,2,3,5), mk_d0(F_V,0,0,0,0,0,4), 64'd0, 64'd0, PRK, 1'b1, 3'd2, 8'd2}, // R2 masked
    '{mk_rt(0,0,2,3,5), mk_d0(F_V,0,0,0,0,0,4), 64'd0, 64'd0, PRK, 1'b1, 3'd3, 8'd1}, // R1 invalid
    '{RT0, mk_d0(8'h00|F_ANOT,0,0,0,0,0,4), 64'd0, 64'd0, PRK, 1'b1, 3'd3, 8'd3},     // R3
    '{RT0, mk_d0(F_V,0,0,0,0,0,8'hFF), 64'd0, 64'd0, PRK, 1'b1, 3'd2, 8'd6},          // R6
    '{RT0, mk_d0(F_V,2'b10,0,0,0,0,4), 64'd0, 64'd0, PRK, 1'b1, 3'd2, 8'd7},          // R7
    '{RT0, mk_d0(F_V|F_ANOT,0,0,0,0,0,4), 64'd0, 64'd0, 64'd0, 1'b1, 3'd3, 8'd8},     // R8 bad proc
    '{RT0, mk_d0(F_V|F_ANOT|F_BLOG|F_FMT,0,0,0,0,0,4), 64'd0, 64'd0, PRK, 1'b0, 3'd3, 8'd9}, // R9
    '{RT0, mk_d0(F_V|F_SIL|F_ESC|F_UESC,0,0,0,0,0,4), ESCB,
      mk_d0(F_V|F_ANOT,0,0,0,0,0,8'd1), PRK, 1'b1, 3'd1, 8'd5},                        // R5
    '{RT0, mk_d0(F_V|F_ANOT,0,0,0,0,0,4), 64'd0, 64'd0, PRK, 1'b0, 3'd2, 8'd8},       // R8 miss
    '{RT0, mk_d0(F_V|F_ANOT|F_FMT,0,0,0,0,0,8'hFF), 64'd0, 64'd0, PRK, 1'b1, 3'd1, 8'd6} // R6 fmt1
  };

  // table model
  logic [63:0] rt_m [64], d0_m [64], d1_m [64], pr_m [64];
  logic [63:0] okv [4];
  logic        cfg_en, cfg_clr;
  logic [1:0]  cfg_sel;
  logic [5:0]  cfg_key;
  logic [63:0] cfg_data;
  logic [7:0]  q_blk;
  logic [15:0] q_idx;
  logic [63:0] q_dat;
  int          q_cnt;
  logic [5:0]  tk;

  assign tk = key(tbl_blk, tbl_idx);
  always_comb begin
    tbl_ack = tbl_req;
    tbl_ok  = (tbl_sel < 3'd4) ? okv[tbl_sel[1:0]][tk] : 1'b1;
    case (tbl_sel)
      3'd0: tbl_rdata = rt_m[tk];
      3'd1: tbl_rdata = d0_m[tk];
      3'd2: tbl_rdata = d1_m[tk];
      3'd3: tbl_rdata = pr_m[tk];
      default: tbl_rdata = 64'd0;
    endcase
  end
  assign pres_ack = pres_req;

  always @(posedge clk) begin
    if (cfg_clr) for (int i = 0; i < 4; i++) okv[i] <= 64'd0;
    if (cfg_en) begin
      okv[cfg_sel][cfg_key] <= 1'b1;
      case (cfg_sel)
        2'd0: rt_m[cfg_key] <= cfg_data;
        2'd1: d0_m[cfg_key] <= cfg_data;
        2'd2: d1_m[cfg_key] <= cfg_data;
        default: pr_m[cfg_key] <= cfg_data;
      endcase
    end
    if (tbl_req && tbl_we) begin
      case (tbl_sel)
        3'd1: d0_m[tk] <= tbl_wdata;
        3'd3: pr_m[tk] <= tbl_wdata;
        3'd4: begin q_blk <= tbl_blk; q_idx <= tbl_idx; q_dat <= tbl_wdata; q_cnt <= q_cnt + 1; end
        default: ;
      endcase
    end
  end

  int checks = 0, errors = 0;
  logic rdy_after, post_done, post_rdy;

  task automatic chk(input logic c, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] s, input logic [5:0] k, input logic [63:0] d);
    @(negedge clk); cfg_en = 1'b1; cfg_sel = s; cfg_key = k; cfg_data = d;
    @(negedge clk); cfg_en = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); cfg_clr = 1'b1;
    @(negedge clk); cfg_clr = 1'b0;
  endtask

  task automatic load(input vec_t v);
    clr();
    put(2'd0, key(1, 5), v.rt);
    put(2'd1, key(2, 3), v.da);
    put(2'd2, key(2, 3), v.dae);
    put(2'd1, key(2, 9), v.db);
    put(2'd2, key(2, 9), 64'd0);
    put(2'd3, key(1, 7), v.pr);
    pres_found = v.fnd;
  endtask

  task automatic run(input logic [9:0] src, output logic [2:0] code);
    int n;
    @(negedge clk); trig_valid = 1'b1; trig_src = src;
    @(negedge clk); trig_valid = 1'b0; rdy_after = trig_ready;
    n = 0;
    while (!done && n < 300) begin @(negedge clk); n++; end
    code = done_code;
    if (!done) begin
      checks++; errors++;
      $display("FAIL hang actual=busy expected=done");
    end
    @(negedge clk); post_done = done; post_rdy = trig_ready;
  endtask

  localparam logic [9:0] SRC = {4'd1, 6'd5};

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors + 1);
    $finish;
  end

  initial begin
    logic [2:0] code;
    rst_n = 1'b0; trig_valid = 1'b0; trig_src = '0; pres_found = 1'b0;
    cfg_en = 1'b0; cfg_clr = 1'b0; cfg_sel = '0; cfg_key = '0; cfg_data = '0; q_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(trig_ready && !done && !tbl_req && !pres_req, "R12 reset",
        {trig_ready, done, tbl_req, pres_req}, 4'b1000);

    for (int v = 0; v < NV; v++) begin
      load(VT[v]);
      run(SRC, code);
      chk(code == VT[v].exp, $sformatf("R%0d vector %0d", VT[v].rq, v), code, VT[v].exp);
    end

    // R1 missing routing entry and busy after accept
    load(VT[0]);
    run({4'd3, 6'd0}, code);
    chk(code == 3'd3, "R1 missing entry", code, 3);
    chk(!rdy_after, "R1 busy after accept", rdy_after, 0);

    // R12 single-cycle done
    chk(!post_done && post_rdy, "R12 done pulse", {post_done, post_rdy}, 2'b01);

    // R4 enqueue with wrap
    clr();
    put(2'd0, key(1, 5), RT0);
    put(2'd1, key(2, 3), mk_d0(F_V|F_ENQ, 0, 0, 4'd2, 1'b0, 15'd3, 8'hFF));
    run(SRC, code);
    chk(code == 3'd2, "R4 enqueue code", code, 2);
    chk(q_blk == 8'd2 && q_idx == 16'd3, "R4 queue slot", {q_blk, q_idx}, {8'd2, 16'd3});
    chk(q_dat == 64'h55, "R4 queue data gen0", q_dat, 64'h55);
    chk(d0_m[key(2,3)][46:32] == 15'd0 && d0_m[key(2,3)][47], "R4 wrap gen",
        d0_m[key(2,3)][47:32], 17'h08000);
    run(SRC, code);
    chk(q_idx == 16'd0 && q_dat == 64'h80000055, "R4 second entry", q_dat, 64'h80000055);
    chk(d0_m[key(2,3)][46:32] == 15'd1, "R4 index step", d0_m[key(2,3)][46:32], 1);

    // R7 notify pair transitions
    clr();
    put(2'd0, key(1, 5), RT0);
    put(2'd1, key(2, 3), mk_d0(F_V, 2'b00, 0, 0, 0, 0, 8'd4));
    put(2'd3, key(1, 7), PRK);
    pres_found = 1'b1;
    run(SRC, code);
    chk(code == 3'd1 && d0_m[key(2,3)][55:54] == 2'b10, "R7 00 to 10",
        {code, d0_m[key(2,3)][55:54]}, {3'd1, 2'b10});
    run(SRC, code);
    chk(code == 3'd2 && d0_m[key(2,3)][55:54] == 2'b11, "R7 10 to 11",
        {code, d0_m[key(2,3)][55:54]}, {3'd2, 2'b11});
    put(2'd1, key(2, 3), mk_d0(F_V, 2'b01, 0, 0, 0, 0, 8'd4));
    run(SRC, code);
    chk(code == 3'd2 && d0_m[key(2,3)][55:54] == 2'b01, "R7 01 stays",
        {code, d0_m[key(2,3)][55:54]}, {3'd2, 2'b01});

    // R9 backlog pending bit
    clr();
    put(2'd0, key(1, 5), RT0);
    put(2'd1, key(2, 3), mk_d0(F_V|F_ANOT|F_BLOG, 0, 0, 0, 0, 0, 8'd2));
    put(2'd3, key(1, 7), mk_pr(1'b1, 8'h01));
    pres_found = 1'b0;
    run(SRC, code);
    chk(code == 3'd2, "R9 backlog code", code, 2);
    chk(pr_m[key(1,7)] == mk_pr(1'b1, 8'h21), "R9 pending byte", pr_m[key(1,7)], mk_pr(1'b1, 8'h21));

    // R10 escalation with pair and data
    clr();
    put(2'd0, key(1, 5), RT0);
    put(2'd1, key(2, 3), mk_d0(F_V|F_SIL|F_ESC, 0, 2'b00, 0, 0, 0, 8'd4));
    put(2'd2, key(2, 3), ESCB);
    put(2'd1, key(2, 9), mk_d0(F_V|F_ENQ|F_ANOT, 0, 0, 4'd4, 0, 15'd0, 8'd1));
    put(2'd3, key(1, 7), PRK);
    pres_found = 1'b1;
    run(SRC, code);
    chk(code == 3'd1, "R10 escalated delivery", code, 1);
    chk(q_blk == 8'd2 && q_idx == 16'd0 && q_dat == 64'h1234, "R10 escalation data", q_dat, 64'h1234);
    chk(d0_m[key(2,3)][53:52] == 2'b10, "R10 pair 00 to 10", d0_m[key(2,3)][53:52], 2);
    run(SRC, code);
    chk(code == 3'd2 && d0_m[key(2,3)][53:52] == 2'b11, "R10 coalesced",
        {code, d0_m[key(2,3)][53:52]}, {3'd2, 2'b11});

    // R11 escalation chain limit
    clr();
    put(2'd0, key(1, 5), RT0);
    put(2'd1, key(2, 3), mk_d0(F_V|F_SIL|F_ESC|F_UESC, 0, 0, 0, 0, 0, 8'd4));
    put(2'd2, key(2, 3), mk_rt(1'b1, 1'b0, 8'd2, 16'd3, 31'd7));
    run(SRC, code);
    chk(code == 3'd4, "R11 chain limit", code, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule